// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets an MDIO management master reach a 32-bit internal register file whose byte addresses are 19 bits wide, although each MDIO frame only carries a 16-bit data field. The two high bits of the frame's 5-bit PHY address select what the frame means. A page frame loads a 10-bit page. That page becomes the upper byte-address bits and splits the register file into 512-byte windows. A register frame names a 16-bit half of one word inside the current window. The remaining three PHY-address bits and the 5-bit register field together locate that half.

A 32-bit word always moves as two frames, low half first. For a write, the low half is held in a staging register. One 32-bit write goes out on the internal bus only when the high half of the same word follows. For a read, the low-half frame triggers a single 32-bit bus read and answers with bits 15:0. The bridge keeps bits 31:16 and returns them in the following high-half frame. Frames that use the bypass encoding or the unused encoding are meant for real PHYs on the same wire. The bridge ignores them and never drives the line for them.

MDC and MDIO are brought into the system clock domain through synchronizers, and the bridge acts on the rising edges of MDC that it detects there. The internal bus is a request/acknowledge master that uses word addresses.

Top module: `mdio_page_bridge`

## Requirements
- R1: After synchronous reset, and after any later reset, `mdio_oe` and `bus_req` are 0 and the page is 0.
- R2: A write frame with PHY address bits [4:3] = 2'b11, PHY bits [2:0] = 0 and register field 0 loads write-data bits [9:0] into the page. The page forms bus word-address bits [16:7], which are byte-address bits [18:9].
- R3: In register mode (PHY bits [4:3] = 2'b10), the bus word address is {page, PHY bits [2:0], register bits [4:1]}. `bus_req` stays high with a stable address and direction until `bus_ack` is seen, and it is low in the cycle after that.
- R4: A register-mode write with register bit 0 = 0 (low half) causes no bus access. A following write with register bit 0 = 1 (high half) to the same word causes exactly one bus write of {high data, low data}.
- R5: A high-half write with no staged low half, or with a staged low half that belongs to a different word, causes no bus write. A staged low half is used only once.
- R6: A low-half register read causes one bus read and returns bits 15:0. A high-half read of the same word that follows it returns bits 31:16 and causes no further bus access.
- R7: A high-half read that is not preceded by a low-half read of the same word returns 16'h0000.
- R8: Frames with PHY bits [4:3] = 2'b00 or 2'b01 never drive MDIO, cause no bus access and leave the page unchanged.
- R9: During a served read, the bridge drives 0 in the second turnaround bit and then drives the 16 data bits, most significant bit first. Each value changes after a rising MDC edge. The line is released after the last data bit.
- R10: A page-mode write with nonzero PHY bits [2:0] or a nonzero register field is ignored. Page-mode reads never drive MDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | MDIO management clock, asynchronous to clk |
| mdio_i | input | 1 | Sampled MDIO line level |
| mdio_o | output | 1 | MDIO value to drive when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| bus_req | output | 1 | Internal bus request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 17 | Word address (byte address bits 18:2) |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench builds the bridge with its default parameters: a 10-bit page, a 32-bit word and two synchronizer stages. The MDC half period is 8 system clocks, which leaves enough slack for the bus to acknowledge between the header and the first data bit. The bus model acknowledges after a random delay of 0 to 2 cycles. That brings the request-hold rule and the read-latch timing within reach. Pages, PHY low bits and register pairs are drawn at random, so the page reaches both its all-zero and its high values. Directed frames cover unmatched staging, orphan high-half reads, bypass and malformed page frames, and reset in the middle of a session.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int HDR_BITS = 12;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] MODE_PAGE = 2'b11;
  localparam logic [1:0] MODE_REG  = 2'b10;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] rga;
  } mdio_hdr_t;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  input  logic              respond,
  input  logic [HALF_W-1:0] rd_half,
  output mdio_hdr_t         hdr,
  output logic              hdr_evt,
  output logic              wr_evt,
  output logic [HALF_W-1:0] wdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int CNT_W = $clog2(HALF_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} st_e;

  logic [SYNC_STAGES-1:0] mdc_sync, dio_sync;
  logic mdc_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        mdc_sync <= mdc;
        dio_sync <= mdio_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        mdc_sync <= {mdc_sync[SYNC_STAGES-2:0], mdc};
        dio_sync <= {dio_sync[SYNC_STAGES-2:0], mdio_i};
      end
    end
  endgenerate

  wire mdc_s = mdc_sync[SYNC_STAGES-1];
  wire din   = dio_sync[SYNC_STAGES-1];
  wire rise  = mdc_s & ~mdc_q;

  st_e                 st;
  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hsh;
  logic [HALF_W-1:0]   dsh, osh;
  logic                ones;

  wire [HDR_BITS-1:0] hnext = {hsh[HDR_BITS-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q   <= 1'b0;
      st      <= S_IDLE;
      cnt     <= '0;
      hsh     <= '0;
      dsh     <= '0;
      osh     <= '0;
      ones    <= 1'b0;
      hdr     <= '0;
      hdr_evt <= 1'b0;
      wr_evt  <= 1'b0;
      wdata   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      mdc_q   <= mdc_s;
      hdr_evt <= 1'b0;
      wr_evt  <= 1'b0;
      if (rise) begin
        case (st)
          S_IDLE: begin
            if (din) ones <= 1'b1;
            else if (ones) begin
              ones <= 1'b0;
              st   <= S_START;
            end
          end
          S_START: begin
            cnt <= '0;
            st  <= din ? S_HDR : S_IDLE;
          end
          S_HDR: begin
            hsh <= hnext;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_BITS - 1)) begin
              cnt <= '0;
              if (hnext[11:10] == OP_WRITE || hnext[11:10] == OP_READ) begin
                hdr     <= hnext;
                hdr_evt <= 1'b1;
                st      <= S_TA;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_TA: begin
            if (cnt == '0) begin
              cnt     <= cnt + 1'b1;
              mdio_oe <= respond && (hdr.op == OP_READ);
              mdio_o  <= 1'b0;
            end else begin
              cnt    <= '0;
              st     <= S_DATA;
              mdio_o <= rd_half[HALF_W-1];
              osh    <= {rd_half[HALF_W-2:0], 1'b0};
            end
          end
          S_DATA: begin
            dsh    <= {dsh[HALF_W-2:0], din};
            cnt    <= cnt + 1'b1;
            mdio_o <= osh[HALF_W-1];
            osh    <= {osh[HALF_W-2:0], 1'b0};
            if (cnt == CNT_W'(HALF_W - 1)) begin
              cnt     <= '0;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              st      <= S_IDLE;
              if (hdr.op == OP_WRITE) begin
                wr_evt <= 1'b1;
                wdata  <= {dsh[HALF_W-2:0], din};
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_half_assembler.sv
module mdio_half_assembler
  import mdio_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  mdio_hdr_t                  hdr,
  input  logic                       hdr_evt,
  input  logic                       wr_evt,
  input  logic [DATA_W/2-1:0]        wdata,
  output logic                       respond,
  output logic [DATA_W/2-1:0]        rd_half,
  output logic [PAGE_W-1:0]          page,
  output logic                       bus_req,
  output logic                       bus_we,
  output logic [PAGE_W+6:0]          bus_addr,
  output logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_ack,
  input  logic [DATA_W-1:0]          bus_rdata
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int WADDR_W = PAGE_W + 7;

  wire [1:0]         mode     = hdr.phy[4:3];
  wire               is_reg   = (mode == MODE_REG);
  wire               is_pgcmd = (mode == MODE_PAGE) && (hdr.phy[2:0] == 3'd0) && (hdr.rga == 5'd0);
  wire               hi_half  = hdr.rga[0];
  wire [WADDR_W-1:0] word     = {page, hdr.phy[2:0], hdr.rga[4:1]};

  logic [HALF_W-1:0]  stage, hold;
  logic [WADDR_W-1:0] stage_tag, hold_tag;
  logic               stage_v, hold_v;

  assign respond = is_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      page      <= '0;
      stage     <= '0;
      stage_tag <= '0;
      stage_v   <= 1'b0;
      hold      <= '0;
      hold_tag  <= '0;
      hold_v    <= 1'b0;
      rd_half   <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_we) begin
          rd_half  <= bus_rdata[HALF_W-1:0];
          hold     <= bus_rdata[DATA_W-1:HALF_W];
          hold_tag <= bus_addr;
          hold_v   <= 1'b1;
        end
      end
      if (hdr_evt && is_reg && hdr.op == OP_READ) begin
        if (!hi_half) begin
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= word;
          hold_v   <= 1'b0;
          rd_half  <= '0;
        end else begin
          rd_half <= (hold_v && hold_tag == word) ? hold : '0;
        end
      end
      if (wr_evt) begin
        if (is_pgcmd) begin
          page <= wdata[PAGE_W-1:0];
        end else if (is_reg) begin
          if (!hi_half) begin
            stage     <= wdata;
            stage_tag <= word;
            stage_v   <= 1'b1;
          end else begin
            stage_v <= 1'b0;
            if (stage_v && stage_tag == word) begin
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= word;
              bus_wdata <= {wdata, stage};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int PAGE_W      = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mdc,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [PAGE_W+6:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_ack,
  input  logic [DATA_W-1:0]    bus_rdata
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int WADDR_W = PAGE_W + 7;

  mdio_hdr_t         hdr;
  logic              hdr_evt, wr_evt, respond;
  logic [HALF_W-1:0] wdata, rd_half;
  logic [PAGE_W-1:0] page;

  mdio_frame_rx #(
    .SYNC_STAGES(SYNC_STAGES),
    .HALF_W     (HALF_W)
  ) u_rx (
    .clk    (clk),
    .rst    (rst),
    .mdc    (mdc),
    .mdio_i (mdio_i),
    .respond(respond),
    .rd_half(rd_half),
    .hdr    (hdr),
    .hdr_evt(hdr_evt),
    .wr_evt (wr_evt),
    .wdata  (wdata),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

  mdio_half_assembler #(
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) u_asm (
    .clk      (clk),
    .rst      (rst),
    .hdr      (hdr),
    .hdr_evt  (hdr_evt),
    .wr_evt   (wr_evt),
    .wdata    (wdata),
    .respond  (respond),
    .rd_half  (rd_half),
    .page     (page),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter int WADDR_W = 17,
  parameter int PAGE_W  = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_we,
  input logic               bus_ack,
  input logic [WADDR_W-1:0] bus_addr,
  input logic               mdio_oe,
  input logic               mdio_o,
  input logic               wr_evt,
  input logic               wr_hi,
  input logic [PAGE_W-1:0]  page
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req); // R3
  AST_WR_ON_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) && bus_we |-> $past(wr_evt) && $past(wr_hi)); // R4
  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o); // R9
  AST_PAGE_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    page != $past(page) |-> $past(wr_evt)); // R2
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(
  .WADDR_W(WADDR_W),
  .PAGE_W (PAGE_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_req (bus_req),
  .bus_we  (bus_we),
  .bus_ack (bus_ack),
  .bus_addr(bus_addr),
  .mdio_oe (mdio_oe),
  .mdio_o  (mdio_o),
  .wr_evt  (wr_evt),
  .wr_hi   (hdr.rga[0]),
  .page    (page)
);

// File: tb/test_mdio_page_bridge.sv
module test_mdio_page_bridge;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe;
  logic        bus_req, bus_we, bus_ack;
  logic [16:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // register file model on the internal bus
  logic [31:0] mem [logic [16:0]];
  int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0, dly = 0;
  logic [16:0] last_wa;
  logic [31:0] last_wd;

  function automatic logic [31:0] dflt(input logic [16:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  function automatic logic [31:0] rd_model(input logic [16:0] a);
    if (mem.exists(a)) return mem[a];
    return dflt(a);
  endfunction

  function automatic logic [16:0] word_of(input logic [9:0] pg, input logic [2:0] p3, input logic [3:0] w4);
    return {pg, p3, w4};
  endfunction

  always @(posedge clk) begin
    if (mdio_oe) oe_cnt++;
    if (rst) bus_ack <= 1'b0;
    else if (bus_ack) bus_ack <= 1'b0;
    else if (bus_req) begin
      if (dly == 0) begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          mem[bus_addr] = bus_wdata;
          wr_cnt++;
          last_wa = bus_addr;
          last_wd = bus_wdata;
        end else begin
          bus_rdata <= rd_model(bus_addr);
          rd_cnt++;
        end
        dly = $urandom % 3;
      end else dly--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic samp;
  task automatic send_bit(input logic b);
    mdio_i = b;
    repeat (HALF) @(posedge clk);
    #1;
    samp = mdio_oe ? mdio_o : 1'b1;
    mdc = 1'b1;
    repeat (HALF) @(posedge clk);
    #1;
    mdc = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, output logic [15:0] rd, output logic ta2, output bit drove);
    int oe0;
    oe0 = oe_cnt;
    rd = '0;
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    if (op == 2'b01) begin
      send_bit(1'b1); send_bit(1'b0);
      ta2 = 1'b1;
      for (int i = 15; i >= 0; i--) send_bit(wd[i]);
    end else begin
      send_bit(1'b1);
      send_bit(1'b1); ta2 = samp;
      for (int i = 15; i >= 0; i--) begin send_bit(1'b1); rd[i] = samp; end
    end
    send_bit(1'b1); send_bit(1'b1);
    drove = (oe_cnt != oe0);
  endtask

  logic [15:0] rdv;
  logic        ta;
  bit          drv;

  task automatic wr16(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    frame(2'b01, phy, ra, d, rdv, ta, drv);
  endtask
  task automatic rd16(input logic [4:0] phy, input logic [4:0] ra);
    frame(2'b10, phy, ra, 16'h0, rdv, ta, drv);
  endtask

  task automatic wr32(input logic [2:0] p3, input logic [3:0] w4, input logic [31:0] d);
    wr16({2'b10, p3}, {w4, 1'b0}, d[15:0]);
    wr16({2'b10, p3}, {w4, 1'b1}, d[31:16]);
  endtask

  task automatic set_page(input logic [9:0] pg);
    wr16(5'b11000, 5'd0, {6'h3F, pg});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    int w0, r0;
    logic [16:0] ea;
    logic [31:0] d;
    void'($urandom(32'h1F2E3D4C));
    bus_rdata = '0;
    do_reset();
    // R1: reset state
    chk(mdio_oe == 1'b0, "R1 oe after reset", {31'd0, mdio_oe}, 0);
    chk(bus_req == 1'b0, "R1 req after reset", {31'd0, bus_req}, 0);

    // R4: low half alone is only staged
    w0 = wr_cnt;
    wr16(5'b10101, 5'b01100, 16'hBEEF);
    chk(wr_cnt == w0, "R4 low half staged only", wr_cnt, w0);
    wr16(5'b10101, 5'b01101, 16'hDEAD);
    chk(wr_cnt == w0 + 1, "R4 pair gives one write", wr_cnt, w0 + 1);
    chk(last_wd == 32'hDEADBEEF, "R4 combined data", last_wd, 32'hDEADBEEF);
    // R3: address with page 0 from R1
    ea = word_of(10'd0, 3'b101, 4'b0110);
    chk(last_wa == ea, "R3 word address page 0", {15'd0, last_wa}, {15'd0, ea});

    // R2: page load
    set_page(10'h2AB);
    wr32(3'b011, 4'hF, 32'h12345678);
    ea = word_of(10'h2AB, 3'b011, 4'hF);
    chk(last_wa == ea, "R2 page sets upper address", {15'd0, last_wa}, {15'd0, ea});

    // R6: read pair
    r0 = rd_cnt;
    rd16(5'b10011, 5'b11110);
    chk(rdv == 16'h5678, "R6 low half read", rdv, 16'h5678);
    chk(ta == 1'b0 && drv, "R9 turnaround zero and driven", {30'd0, ta, drv}, 1);
    chk(mdio_oe == 1'b0, "R9 released after frame", {31'd0, mdio_oe}, 0);
    rd16(5'b10011, 5'b11111);
    chk(rdv == 16'h1234, "R6 high half read", rdv, 16'h1234);
    chk(rd_cnt == r0 + 1, "R6 single bus read per pair", rd_cnt, r0 + 1);

    // R6 on an untouched word (default pattern)
    ea = word_of(10'h2AB, 3'b000, 4'h3);
    d = dflt(ea);
    rd16(5'b10000, 5'b00110);
    chk(rdv == d[15:0], "R6 default low", rdv, d[15:0]);
    rd16(5'b10000, 5'b00111);
    chk(rdv == d[31:16], "R6 default high", rdv, d[31:16]);

    // R7: orphan high read
    r0 = rd_cnt;
    rd16(5'b10010, 5'b00011);
    chk(rdv == 16'h0000, "R7 orphan high read", rdv, 0);
    chk(rd_cnt == r0, "R7 no bus read", rd_cnt, r0);

    // R5: unmatched high writes
    w0 = wr_cnt;
    wr16(5'b10001, 5'b00011, 16'h1111);
    chk(wr_cnt == w0, "R5 high without low", wr_cnt, w0);
    wr16(5'b10001, 5'b00100, 16'h2222);
    wr16(5'b10001, 5'b00111, 16'h3333);
    chk(wr_cnt == w0, "R5 high to other word", wr_cnt, w0);
    wr16(5'b10001, 5'b00101, 16'h4444);
    chk(wr_cnt == w0, "R5 staged low consumed", wr_cnt, w0);

    // R8: bypass and unused modes
    w0 = wr_cnt; r0 = rd_cnt;
    rd16(5'b00011, 5'b00010);
    chk(!drv, "R8 bypass read not driven", {31'd0, drv}, 0);
    rd16(5'b01000, 5'b00000);
    chk(!drv, "R8 mode 01 read not driven", {31'd0, drv}, 0);
    wr16(5'b00000, 5'b00000, 16'h0155);
    wr16(5'b01000, 5'b00000, 16'h0155);
    chk(wr_cnt == w0 && rd_cnt == r0, "R8 no bus access", wr_cnt + rd_cnt, w0 + r0);

    // R10: malformed page write and page read
    wr16(5'b11001, 5'd0, 16'h0155);
    wr16(5'b11000, 5'd4, 16'h0155);
    rd16(5'b11000, 5'd0);
    chk(!drv, "R10 page read not driven", {31'd0, drv}, 0);
    wr32(3'b110, 4'h2, 32'hA5A55A5A);
    ea = word_of(10'h2AB, 3'b110, 4'h2);
    chk(last_wa == ea, "R8 R10 page unchanged", {15'd0, last_wa}, {15'd0, ea});

    // random pairs
    for (int n = 0; n < 20; n++) begin
      logic [9:0]  pg;
      logic [2:0]  p3;
      logic [3:0]  w4;
      logic [31:0] v;
      pg = n[0] ? 10'h3FF - 10'(n) : 10'($urandom);
      p3 = 3'($urandom);
      w4 = 4'($urandom);
      v  = $urandom;
      ea = word_of(pg, p3, w4);
      set_page(pg);
      wr32(p3, w4, v);
      chk(last_wa == ea && last_wd == v, "R3 R4 random write", last_wd, v);
      rd16({2'b10, p3}, {w4, 1'b0});
      chk(rdv == v[15:0], "R6 random low", rdv, v[15:0]);
      rd16({2'b10, p3}, {w4, 1'b1});
      chk(rdv == v[31:16], "R6 random high", rdv, v[31:16]);
    end

    // R1: reset clears the page
    do_reset();
    chk(mdio_oe == 1'b0 && bus_req == 1'b0, "R1 outputs after second reset", {30'd0, mdio_oe, bus_req}, 0);
    wr32(3'b001, 4'h1, 32'h0BADF00D);
    ea = word_of(10'd0, 3'b001, 4'h1);
    chk(last_wa == ea, "R1 page zero after reset", {15'd0, last_wa}, {15'd0, ea});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule